// File: doc/BRIEF.md
# Synchronous Dual-Strobe Up/Down Counter

This block is a 16-bit binary counter steered by two independent count strobes, one that raises the count and one that lowers it. Neither strobe clocks any register. Each strobe is first brought into the system clock domain by a two-flop synchroniser. A third register then finds its rising edge. The edge events select the next value of a single counter register on the system clock: count plus one, count minus one, or hold.

A synchronous parallel load sets the counter from a 16-bit bus. An enable gates counting. Two flag outputs report wrap-around: a carry when an up step leaves the all-ones value, and a borrow when a down step leaves zero. Each flag is a single-cycle pulse. The carry of one stage can drive the up strobe of the next stage, and the borrow can drive its down strobe, to build wider counters. `rst_n` is an asynchronous active-low reset. Its release must be synchronous to `clk`.

A strobe must stay at each level for at least two system clocks. The count changes on the third rising clock edge after the strobe rises, and a flag is visible during the cycle that follows that edge.

Top module: `updn_dual_strobe_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and `carry_o` and `borrow_o` are 0.
- R2: A rising edge on `inc_strobe_i` raises `count_o` by one. The new value appears on the third rising `clk` edge after the strobe is first sampled high.
- R3: A rising edge on `dec_strobe_i` lowers `count_o` by one, with the same latency as R2.
- R4: When `load_i` is high at a clock edge, `count_o` takes `load_val_i` at that edge. Any strobe edge that falls due at that edge is discarded, and no flag is raised.
- R5: When `en_i` is low at the edge where a strobe edge falls due, the count holds and no flag is raised.
- R6: An up step taken from 16'hFFFF wraps the count to 0. The same edge raises `carry_o` for exactly one cycle.
- R7: A down step taken from 0 wraps the count to 16'hFFFF. The same edge raises `borrow_o` for exactly one cycle.
- R8: When up and down edges fall due at the same edge, the count holds and neither flag is raised.
- R9: A strobe held high for many cycles produces only one step. Counting follows edges, not levels.
- R10: When `carry_o` drives `inc_strobe_i` of a second stage and `borrow_o` drives its `dec_strobe_i`, the second stage counts the wraps of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Synchronous parallel load, has priority over counting |
| load_val_i | input | 16 | Value taken on a load |
| en_i | input | 1 | Count enable |
| inc_strobe_i | input | 1 | Up-count strobe, acts on its rising edge |
| dec_strobe_i | input | 1 | Down-count strobe, acts on its rising edge |
| count_o | output | 16 | Current count |
| carry_o | output | 1 | One-cycle pulse on an up wrap |
| borrow_o | output | 1 | One-cycle pulse on a down wrap |

## Verification
The assertions check on every cycle that:
- a load lands exactly;
- the count moves by at most one per cycle outside a load;
- a disabled cycle leaves the count and flags untouched;
- a flag appears only together with its matching wrap;
- the two flags never appear together.

The latency of three edges, the loss of a strobe edge under a load, the handling of simultaneous edges, the edge-versus-level behaviour and the cascade into a second stage all depend on the history of the strobes. Only the bench's directed and random scenarios show these, by comparing the ports with a model step by step.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Operation chosen for the counter register in one system clock.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_LOAD = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/updn_strobe_sync.sv
module updn_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic [SYNC_STAGES-1:0] sh_d;
  logic                   hist_q;

  assign sh_d[0] = strobe_i;
  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_chain
    assign sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hist_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      hist_q <= sh_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~hist_q;
endmodule

// File: rtl/updn_op_sel.sv
module updn_op_sel
  import updn_pkg::*;
(
  input  logic    load_i,
  input  logic    en_i,
  input  logic    inc_ev_i,
  input  logic    dec_ev_i,
  output cnt_op_e op_o
);
  always_comb begin
    op_o = OP_HOLD;
    if (load_i) begin
      op_o = OP_LOAD;
    end else if (en_i) begin
      unique case ({inc_ev_i, dec_ev_i})
        2'b10:   op_o = OP_INC;
        2'b01:   op_o = OP_DEC;
        default: op_o = OP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o,
  output logic             borrow_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             carry_q, carry_d;
  logic             borrow_q, borrow_d;

  always_comb begin
    cnt_d    = cnt_q;
    carry_d  = 1'b0;
    borrow_d = 1'b0;
    unique case (op_i)
      OP_LOAD: cnt_d = load_val_i;
      OP_INC: begin
        cnt_d   = cnt_q + CNT_ONE;
        carry_d = (cnt_q == CNT_MAX);
      end
      OP_DEC: begin
        cnt_d    = cnt_q - CNT_ONE;
        borrow_d = (cnt_q == '0);
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
    end
  end

  assign count_o  = cnt_q;
  assign carry_o  = carry_q;
  assign borrow_o = borrow_q;
endmodule

// File: rtl/updn_dual_strobe_counter.sv
module updn_dual_strobe_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             en_i,
  input  logic             inc_strobe_i,
  input  logic             dec_strobe_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o,
  output logic             borrow_o
);
  localparam int N_STROBES = 2;

  logic [N_STROBES-1:0] strobe_in;
  logic [N_STROBES-1:0] strobe_ev;
  cnt_op_e              op;

  assign strobe_in = {dec_strobe_i, inc_strobe_i};

  for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
    updn_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_in[g]),
      .rise_o   (strobe_ev[g])
    );
  end

  updn_op_sel u_sel (
    .load_i   (load_i),
    .en_i     (en_i),
    .inc_ev_i (strobe_ev[0]),
    .dec_ev_i (strobe_ev[1]),
    .op_o     (op)
  );

  updn_count_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .carry_o    (carry_o),
    .borrow_o   (borrow_o)
  );
endmodule

// File: rtl/updn_dual_strobe_counter_chk.sv
module updn_dual_strobe_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic             en_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o,
  input logic             borrow_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_i)) |-> (count_o == $past(load_val_i)));

  assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_i) && !$past(en_i))
      |-> ($stable(count_o) && !carry_o && !borrow_o));

  assert_unit_step_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_i))
      |-> ((count_o == $past(count_o)) || (count_o == $past(count_o) + ONE)
           || (count_o == $past(count_o) - ONE)));

  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && carry_o) |-> ((count_o == '0) && ($past(count_o) == '1)));

  assert_borrow_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && borrow_o) |-> ((count_o == '1) && ($past(count_o) == '0)));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_o && borrow_o));
endmodule

bind updn_dual_strobe_counter updn_dual_strobe_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .en_i       (en_i),
  .count_o    (count_o),
  .carry_o    (carry_o),
  .borrow_o   (borrow_o)
);

// File: tb/tb_updn_dual_strobe_counter.sv
module tb_updn_dual_strobe_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i;
  logic [15:0] load_val_i;
  logic        en_i;
  logic        inc_i;
  logic        dec_i;
  logic [15:0] count_o;
  logic        carry_o;
  logic        borrow_o;
  logic [15:0] hi_count;
  logic        hi_carry;
  logic        hi_borrow;

  int checks = 0;
  int errors = 0;
  logic [15:0] cnt_m;
  logic [15:0] hi_m;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updn_dual_strobe_counter dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .en_i(en_i), .inc_strobe_i(inc_i), .dec_strobe_i(dec_i),
    .count_o(count_o), .carry_o(carry_o), .borrow_o(borrow_o)
  );

  // Second stage chained on the first stage's flags (R10).
  updn_dual_strobe_counter dut_hi (
    .clk(clk), .rst_n(rst_n), .load_i(1'b0), .load_val_i(16'h0000),
    .en_i(1'b1), .inc_strobe_i(carry_o), .dec_strobe_i(borrow_o),
    .count_o(hi_count), .carry_o(hi_carry), .borrow_o(hi_borrow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected {carry, borrow, count} for one strobe step.
  function automatic logic [17:0] model(input logic [15:0] c, input logic up,
                                        input logic dn, input logic en);
    if (!en || (up == dn)) return {2'b00, c};
    if (up) return {(c == 16'hFFFF), 1'b0, c + 16'd1};
    return {1'b0, (c == 16'h0000), c - 16'd1};
  endfunction

  // Called just after a falling edge. Strobes rise, result sampled three edges later.
  task automatic step(input logic up, input logic dn, input int hold, input string req);
    logic [17:0] e;
    e = model(cnt_m, up, dn, en_i);
    inc_i = up;
    dec_i = dn;
    repeat (3) @(negedge clk);
    chk({req, " count"}, {16'h0, count_o}, {16'h0, e[15:0]});
    chk({req, " carry"}, {31'h0, carry_o}, {31'h0, e[17]});
    chk({req, " borrow"}, {31'h0, borrow_o}, {31'h0, e[16]});
    if (hold > 3) repeat (hold - 3) @(negedge clk);
    inc_i = 1'b0;
    dec_i = 1'b0;
    repeat (3) @(negedge clk);
    cnt_m = e[15:0];
    if (e[17]) hi_m = hi_m + 16'd1;
    if (e[16]) hi_m = hi_m - 16'd1;
    chk({req, " flags cleared"}, {30'h0, carry_o, borrow_o}, 32'h0);
    chk("R10 second stage", {16'h0, hi_count}, {16'h0, hi_m});
  endtask

  task automatic do_load(input logic [15:0] v);
    load_i = 1'b1;
    load_val_i = v;
    @(negedge clk);
    load_i = 1'b0;
    chk("R4 load", {16'h0, count_o}, {16'h0, v});
    cnt_m = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED1234);
    rst_n = 1'b0; load_i = 1'b0; load_val_i = '0; en_i = 1'b1; inc_i = 1'b0; dec_i = 1'b0;
    cnt_m = '0; hi_m = '0;
    repeat (5) @(negedge clk);
    chk("R1 reset count", {16'h0, count_o}, 32'h0);
    chk("R1 reset flags", {30'h0, carry_o, borrow_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    step(1'b1, 1'b0, 3, "R2 up");
    step(1'b0, 1'b1, 3, "R3 down");
    step(1'b0, 1'b1, 3, "R7 down wrap");
    step(1'b1, 1'b0, 3, "R6 up wrap");
    do_load(16'hFFFE);
    step(1'b1, 1'b0, 3, "R2 up to max");
    step(1'b1, 1'b0, 3, "R6 wrap after load");
    en_i = 1'b0;
    step(1'b1, 1'b0, 3, "R5 disabled up");
    step(1'b0, 1'b1, 3, "R5 disabled down");
    en_i = 1'b1;
    step(1'b1, 1'b1, 3, "R8 both edges");
    step(1'b1, 1'b0, 14, "R9 long level");
    step(1'b0, 1'b1, 9, "R9 long level down");

    // R4: up edge falls due while load is held; it must be lost.
    load_i = 1'b1; load_val_i = 16'h1234; inc_i = 1'b1;
    repeat (4) @(negedge clk);
    load_i = 1'b0;
    repeat (3) @(negedge clk);
    inc_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 edge dropped under load", {16'h0, count_o}, 32'h1234);
    chk("R4 no flag under load", {30'h0, carry_o, borrow_o}, 32'h0);
    cnt_m = 16'h1234;

    // R1: reset in the middle of a run.
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", {16'h0, count_o}, 32'h0);
    chk("R1 mid-run reset stage two", {16'h0, hi_count}, 32'h0);
    rst_n = 1'b1; cnt_m = '0; hi_m = '0;
    @(negedge clk);

    for (int n = 0; n < 160; n++) begin
      int r;
      r = $urandom % 16;
      en_i = (($urandom % 8) != 0);
      if (r == 0) do_load(16'(($urandom % 4 == 0) ? 16'hFFFF : $urandom));
      else if (r == 1) do_load(16'h0000);
      else if (r < 9) step(1'b1, ($urandom % 10) == 0, 3 + ($urandom % 4), "R2 random");
      else step(($urandom % 10) == 0, 1'b1, 3 + ($urandom % 4), "R3 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule